// File: doc/BRIEF.md
# Program memory table read unit

This unit turns table-read requests into accesses of a 24-bit-wide instruction memory and returns 16 bits of the fetched word. It holds an 8-bit page register. A 16-bit pointer supplied with each request is placed below that page to form a 24-bit byte address. Bit 0 of the byte address selects a byte. The remaining 23 bits address one instruction word. The top page bit chooses between the user half and the configuration half of program space.

For reads, each instruction word looks like two 16-bit lanes side by side. The low lane holds word bits 15:0. The high lane holds bits 23:16 and, above them, a phantom byte that always reads as zero. Each lane can be read as a whole word or as a single byte. A request is presented for one cycle. The unit drives a synchronous memory read port in that same cycle and returns the selected data with a one-cycle valid pulse on the next cycle. A new request may follow on every cycle.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the page register reads 0x0000 and `rsp_valid` is low.
- R2: A cycle with `pg_wr_en` high stores `pg_wr_data[7:0]` in the page register, visible from the next cycle. `pg_rd_data[15:8]` always reads zero, whatever was written there.
- R3: In a cycle with `req_valid` high, `mem_en` is high and `mem_addr` equals {page, `req_ptr[15:1]`}. `mem_addr[22]` is page bit 7: 0 selects the user half and 1 selects the configuration half.
- R4: The page part of `mem_addr` never depends on the pointer. Pointer values 0xFFFF and 0x0000 under the same page give word addresses {page,0x7FFF} and {page,0x0000}, with no carry or borrow into the page.
- R5: `rsp_valid` is high for exactly one cycle, in the cycle after each request, and is low in every other cycle. `rsp_data` is zero while `rsp_valid` is low.
- R6: A low-lane word read (`req_high`=0, `req_byte`=0) returns word bits 15:0, whatever the value of `req_ptr[0]`.
- R7: A low-lane byte read (`req_high`=0, `req_byte`=1) returns bits 7:0 when `req_ptr[0]`=0 and bits 15:8 when `req_ptr[0]`=1, zero-extended to 16 bits.
- R8: A high-lane word read (`req_high`=1, `req_byte`=0) returns {8'h00, word bits 23:16}, whatever the value of `req_ptr[0]`.
- R9: A high-lane byte read returns {8'h00, bits 23:16} when `req_ptr[0]`=0. When `req_ptr[0]`=1 it returns 0x0000, because that byte is the phantom byte.
- R10: A request in the same cycle as a page write uses the page value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_wr_en | input | 1 | Write strobe for the page register |
| pg_wr_data | input | 16 | Page register write data; only bits 7:0 are stored |
| pg_rd_data | output | 16 | Page register view, upper byte zero |
| req_valid | input | 1 | Table-read request strobe |
| req_high | input | 1 | 1 = high lane, 0 = low lane |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| req_ptr | input | 16 | Pointer within the page |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 23 | Instruction word address |
| mem_rdata | input | 24 | Memory data, one cycle after mem_en |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Response data |

## Verification
A corrupted page register shows up in the page field of `mem_addr` during the very next request. It also shows on `pg_rd_data` at once, so a single comparison on every cycle catches it. A mode, lane or byte-select flag that is captured wrongly spoils only the response one cycle after its request. For that reason, every lane and byte-select combination is issued with data in which each byte differs. A lost or duplicated valid bit is visible on the first cycle after any request, or after any idle cycle.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    localparam int PAGE_W = 8;
    localparam int PTR_W  = 16;
    localparam int MEM_W  = 24;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              pend;
        logic              high;
        logic              byte_m;
        logic              lsb;
    } tblrd_state_t;
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen #(
    parameter int PAGE_W = 8,
    parameter int PTR_W  = 16,
    localparam int ADDR_W = PAGE_W + PTR_W - 1
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] word_addr
);
    // Page sits above the pointer; the pointer is never added to it,
    // so wrap stays inside the page.
    always_comb begin
        word_addr = {page, ptr[PTR_W-1:1]};
    end
endmodule

// File: rtl/tblrd_lane_sel.sv
module tblrd_lane_sel #(
    parameter int MEM_W  = 24,
    parameter int DATA_W = 16,
    localparam int HALF_W = DATA_W / 2,
    localparam int HI_W   = MEM_W - DATA_W
) (
    input  logic [MEM_W-1:0]  word,
    input  logic              high,
    input  logic              byte_m,
    input  logic              lsb,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] hi_lane;

    always_comb begin
        hi_lane = '0;
        hi_lane[HI_W-1:0] = word[MEM_W-1:DATA_W];
        data = '0;
        if (high) begin
            if (!(byte_m && lsb)) begin
                data = hi_lane;
            end
        end else if (byte_m) begin
            if (lsb) begin
                data[HALF_W-1:0] = word[DATA_W-1:HALF_W];
            end else begin
                data[HALF_W-1:0] = word[HALF_W-1:0];
            end
        end else begin
            data = word[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
    import tblrd_pkg::*;
#(
    localparam int ADDR_W = PAGE_W + PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_wr_en,
    input  logic [15:0]       pg_wr_data,
    output logic [15:0]       pg_rd_data,
    input  logic              req_valid,
    input  logic              req_high,
    input  logic              req_byte,
    input  logic [PTR_W-1:0]  req_ptr,
    output logic              mem_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [MEM_W-1:0]  mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    tblrd_state_t st_d, st_q;
    logic [DATA_W-1:0] lane_data;

    tblrd_addr_gen #(.PAGE_W(PAGE_W), .PTR_W(PTR_W)) i_addr (
        .page      (st_q.page),
        .ptr       (req_ptr),
        .word_addr (mem_addr)
    );

    tblrd_lane_sel #(.MEM_W(MEM_W), .DATA_W(DATA_W)) i_lane (
        .word   (mem_rdata),
        .high   (st_q.high),
        .byte_m (st_q.byte_m),
        .lsb    (st_q.lsb),
        .data   (lane_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pend   = req_valid;
        if (req_valid) begin
            st_d.high   = req_high;
            st_d.byte_m = req_byte;
            st_d.lsb    = req_ptr[0];
        end
        if (pg_wr_en) begin
            st_d.page = pg_wr_data[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_en     = req_valid;
        pg_rd_data = '0;
        pg_rd_data[PAGE_W-1:0] = st_q.page;
        rsp_valid  = st_q.pend;
        rsp_data   = st_q.pend ? lane_data : '0;
    end

    a_r5_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        pg_wr_en |=> pg_rd_data[PAGE_W-1:0] == $past(pg_wr_data[PAGE_W-1:0]));
    a_r3_page_field: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> mem_addr[ADDR_W-1 -: PAGE_W] == pg_rd_data[PAGE_W-1:0]);
    a_r8_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_high)) |-> rsp_data[DATA_W-1:DATA_W/2] == '0);
    a_r9_phantom_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_high) && $past(req_byte) && $past(req_ptr[0]))
        |-> rsp_data == '0);
endmodule

// File: tb/test_tblrd_unit.sv
module test_tblrd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr_en = 1'b0;
    logic [15:0] pg_wr_data = '0;
    logic [15:0] pg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_high = 1'b0;
    logic        req_byte = 1'b0;
    logic [15:0] req_ptr = '0;
    logic        mem_en;
    logic [22:0] mem_addr;
    logic [23:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_page;
    logic        exp_v;
    logic [15:0] exp_d;
    string       exp_tag;

    always #2.5 clk = ~clk;

    tblrd_unit i_tblrd_unit (
        .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_wr_data(pg_wr_data),
        .pg_rd_data(pg_rd_data), .req_valid(req_valid), .req_high(req_high),
        .req_byte(req_byte), .req_ptr(req_ptr), .mem_en(mem_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    function automatic logic [23:0] mem_word(input logic [22:0] a);
        logic [31:0] h;
        h = {9'd0, a} * 32'h0009_E377 + 32'h00A5_3C17;
        return h[23:0];
    endfunction

    function automatic logic [15:0] expect_data(input logic [23:0] w,
            input bit hi, input bit by, input bit lsb);
        if (hi) return (by && lsb) ? 16'h0000 : {8'h00, w[23:16]};
        if (by) return lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
        return w[15:0];
    endfunction

    task automatic check(input bit ok, input string tag,
            input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // memory model: synchronous read
    always @(posedge clk) if (mem_en) mem_rdata <= mem_word(mem_addr);

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_page <= 8'h00;
            exp_v  <= 1'b0;
            exp_d  <= '0;
        end else begin
            exp_v <= req_valid;
            if (req_valid) begin
                exp_d   <= expect_data(mem_word({m_page, req_ptr[15:1]}),
                                       req_high, req_byte, req_ptr[0]);
                exp_tag <= req_high ? (req_byte ? "R9" : "R8")
                                    : (req_byte ? "R7" : "R6");
            end
            if (pg_wr_en) m_page <= pg_wr_data[7:0];
        end
    end

    // compare every cycle away from the edge
    always @(negedge clk) begin
        if (!rst_n) begin
            check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
            check(pg_rd_data == 16'h0, "R1 page", pg_rd_data, 0);
        end else if (!done) begin
            check(pg_rd_data == {8'h00, m_page}, "R2 page view", pg_rd_data, {8'h00, m_page});
            check(rsp_valid == exp_v, "R5 valid", rsp_valid, exp_v);
            if (exp_v) check(rsp_data == exp_d, exp_tag, rsp_data, exp_d);
            else check(rsp_data == 16'h0, "R5 idle data", rsp_data, 0);
            check(mem_en == req_valid, "R3 mem_en", mem_en, req_valid);
            if (req_valid)
                check(mem_addr == {m_page, req_ptr[15:1]}, "R3 R4 mem_addr",
                      mem_addr, {m_page, req_ptr[15:1]});
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        req_valid = 0; pg_wr_en = 0;
    endtask

    task automatic req(input bit hi, input bit by, input logic [15:0] p);
        @(posedge clk); #1;
        pg_wr_en = 0;
        req_valid = 1; req_high = hi; req_byte = by; req_ptr = p;
    endtask

    task automatic wr_page(input logic [15:0] v);
        @(posedge clk); #1;
        req_valid = 0;
        pg_wr_en = 1; pg_wr_data = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle();
        // R6..R9 at page 0, all lane/byte-select combinations
        for (int k = 0; k < 8; k++) req(k[2], k[1], 16'h1230 + 16'(k[0]));
        idle();
        // R2: upper byte of write data is dropped
        wr_page(16'hFF3C);
        idle();
        for (int k = 0; k < 8; k++) req(k[2], k[1], 16'h8A40 + 16'(k[0]) + 16'(k*2));
        // R4: wrap at both ends of the pointer
        req(0, 0, 16'hFFFF);
        req(0, 1, 16'hFFFF);
        req(1, 0, 16'h0000);
        req(1, 1, 16'hFFFE);
        idle();
        // R3: configuration half (page bit 7 set)
        wr_page(16'h00F8);
        req(0, 0, 16'h0006);
        req(1, 0, 16'h0008);
        req(1, 1, 16'h000B);
        // R10: request and page write in the same cycle
        @(posedge clk); #1;
        req_valid = 1; req_high = 0; req_byte = 0; req_ptr = 16'h4444;
        pg_wr_en = 1; pg_wr_data = 16'h0011;
        req(0, 1, 16'h4445);
        idle();
        idle();
        // gaps between requests
        for (int k = 0; k < 6; k++) begin
            req(k[0], k[1], 16'(k * 16'h2F13));
            idle();
        end
        idle();
        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule